// File: doc/BRIEF.md
# Iterative 32x32 Multiplier with High-Word Register

This unit multiplies the low 32 bits of two 64-bit operands. It returns the full 64-bit product, either unsigned or signed. In the signed form each 32-bit operand is sign-extended before the product is formed. When a multiply finishes, the upper half of the product is also loaded into a dedicated 32-bit high-word register. A flag-setting variant additionally reports negative and zero condition flags derived from the 64-bit result.

The multiply is iterative. The parameter `STEP_BITS` sets how many multiplier bits are consumed per clock, so one multiply takes `32/STEP_BITS` cycles after it is accepted. The high-word register is always readable through a zero-extended 64-bit port. It can be written through a strobe that stores the low 32 bits of the XOR of the two operand inputs.

Top module: `mulhi_unit`

## Requirements
- R1: With `signed_i` low, `product_o` equals the unsigned product of `a_i[31:0]` and `b_i[31:0]` as a 64-bit value.
- R2: With `signed_i` high, `product_o` equals the product of the two 32-bit operand halves, each sign-extended from bit 31 to 64 bits, truncated to 64 bits.
- R3: On the cycle a multiply completes, the high-word register takes `product[63:32]`.
- R4: `hi_rdata_o[31:0]` shows the high-word register, and `hi_rdata_o[63:32]` is always zero.
- R5: A cycle with `hi_wr_i` high and no multiply completing stores `(a_i ^ b_i)[31:0]` in the high-word register, visible on the next cycle.
- R6: If a multiply completes in the same cycle as `hi_wr_i` is sampled, the register takes the product's upper half and the write is dropped.
- R7: `valid_o` pulses for one cycle exactly `32/STEP_BITS` cycles after a start is accepted. `product_o` holds its value until the next completion.
- R8: `start_i` is accepted only while `busy_o` is low. A start raised while busy produces no result and changes neither the product nor the high-word register.
- R9: With `setcc_i` high at acceptance, `cc_valid_o` pulses together with `valid_o`. At the same time `neg_o` becomes `product[63]` and `zero_o` becomes 1 exactly when the 64-bit product is zero.
- R10: A multiply accepted with `setcc_i` low leaves `neg_o` and `zero_o` unchanged, and `cc_valid_o` stays low.
- R11: After reset, `busy_o`, `valid_o`, `cc_valid_o`, `neg_o` and `zero_o` are 0, `product_o` is 0, and the high-word register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a multiply (accepted when not busy) |
| signed_i | input | 1 | 1 = signed multiply, 0 = unsigned |
| setcc_i | input | 1 | 1 = update negative/zero flags on completion |
| a_i | input | 64 | First operand; low 32 bits used |
| b_i | input | 64 | Second operand; low 32 bits used |
| hi_wr_i | input | 1 | Write `(a_i ^ b_i)[31:0]` into the high-word register |
| busy_o | output | 1 | Multiply in progress |
| valid_o | output | 1 | One-cycle completion pulse |
| product_o | output | 64 | Last completed product |
| cc_valid_o | output | 1 | Completion pulse of a flag-setting multiply |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| hi_rdata_o | output | 64 | High-word register, zero-extended |

## Verification
The bench builds the unit with the default `STEP_BITS` of 4, which gives eight iteration cycles per multiply. That window is long enough to raise an extra start in the middle of a multiply. It also lets a high-word write be placed on the exact completion cycle to exercise the priority rule. Signed operands with bit 31 set reach the final correction step, and extreme values such as the most negative 32-bit number and all-ones bring out carry and sign corner cases.

// File: rtl/mulhi_pkg.sv
// Package: shared widths for the multiplier with high-word register.
// Assumes a 64-bit datapath whose low half feeds the multiply.
package mulhi_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;

    // Completion bundle handed from the iterative core to its consumers.
    typedef struct packed {
        logic              fin;
        logic              set_cc;
        logic [DATA_W-1:0] prod;
    } mul_fin_t;
endpackage

// File: rtl/mulhi_core.sv
// Module: iterative shift-add multiplier over the low halves of two operands.
// Consumes STEP_BITS multiplier bits per cycle; signed products use a
// sign-extended multiplicand and subtract a final correction when the
// multiplier's bit 31 is set. Assumes STEP_BITS divides HALF_W.
module mulhi_core
    import mulhi_pkg::*;
#(
    parameter int STEP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic              setcc_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              busy_o,
    output mul_fin_t          fin_o
);
    localparam int STEPS = HALF_W / STEP_BITS;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] mcand_q;
    logic [DATA_W-1:0] base_q;
    logic [HALF_W-1:0] mplier_q;
    logic              corr_q;
    logic              cc_q;

    logic              accept;
    logic              last_step;
    logic [DATA_W-1:0] pp;
    logic [DATA_W-1:0] acc_nxt;
    logic [DATA_W-1:0] corr_val;
    logic [DATA_W-1:0] a_ext;

    // Accept a new request only when idle.
    assign accept    = start_i & ~busy_q;
    assign last_step = busy_q & (cnt_q == CNT_W'(STEPS - 1));

    // Extend the multiplicand according to the signed/unsigned select.
    always_comb begin
        a_ext = {{HALF_W{signed_i & a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
    end

    // Partial product for the multiplier bits consumed this cycle.
    always_comb begin
        pp = '0;
        for (int i = 0; i < STEP_BITS; i++) begin
            if (mplier_q[i]) pp = pp + (mcand_q << i);
        end
    end

    // Running sum and signed correction for the final product.
    always_comb begin
        acc_nxt  = acc_q + pp;
        corr_val = corr_q ? {base_q[HALF_W-1:0], {HALF_W{1'b0}}} : '0;
    end

    // Iteration state: load on accept, shift and accumulate while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            acc_q    <= '0;
            mcand_q  <= '0;
            base_q   <= '0;
            mplier_q <= '0;
            corr_q   <= 1'b0;
            cc_q     <= 1'b0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            cnt_q    <= '0;
            acc_q    <= '0;
            mcand_q  <= a_ext;
            base_q   <= a_ext;
            mplier_q <= b_i[HALF_W-1:0];
            corr_q   <= signed_i & b_i[HALF_W-1];
            cc_q     <= setcc_i;
        end else if (busy_q) begin
            acc_q    <= acc_nxt;
            mcand_q  <= mcand_q << STEP_BITS;
            mplier_q <= mplier_q >> STEP_BITS;
            cnt_q    <= cnt_q + 1'b1;
            if (last_step) busy_q <= 1'b0;
        end
    end

    // Completion bundle, valid only on the final iteration.
    always_comb begin
        fin_o.fin    = last_step;
        fin_o.set_cc = cc_q;
        fin_o.prod   = acc_nxt - corr_val;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/mulhi_hireg.sv
// Module: architectural high-word register.
// A completing multiply loads the product's upper half and wins over a
// same-cycle software write, which stores the low half of a XOR b.
module mulhi_hireg
    import mulhi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mul_fin_t          fin_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [HALF_W-1:0] hi_q;
    logic [DATA_W-1:0] wr_val;

    // Value a software write would store.
    assign wr_val = a_i ^ b_i;

    // Register update with multiply priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (fin_i.fin) begin
            hi_q <= fin_i.prod[DATA_W-1:HALF_W];
        end else if (wr_i) begin
            hi_q <= wr_val[HALF_W-1:0];
        end
    end

    // Reads are zero-extended to the full width.
    assign rdata_o = {{(DATA_W-HALF_W){1'b0}}, hi_q};
endmodule

// File: rtl/mulhi_result.sv
// Module: result register, completion pulses and condition flags.
// Holds the last product; flags change only on flag-setting completions.
module mulhi_result
    import mulhi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mul_fin_t          fin_i,
    output logic              valid_o,
    output logic              cc_valid_o,
    output logic [DATA_W-1:0] product_o,
    output logic              neg_o,
    output logic              zero_o
);
    logic              valid_q;
    logic              cc_valid_q;
    logic [DATA_W-1:0] prod_q;
    logic              neg_q;
    logic              zero_q;

    // Completion pulses and held product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            cc_valid_q <= 1'b0;
            prod_q     <= '0;
        end else begin
            valid_q    <= fin_i.fin;
            cc_valid_q <= fin_i.fin & fin_i.set_cc;
            if (fin_i.fin) prod_q <= fin_i.prod;
        end
    end

    // Negative and zero flags from flag-setting multiplies only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            zero_q <= 1'b0;
        end else if (fin_i.fin && fin_i.set_cc) begin
            neg_q  <= fin_i.prod[DATA_W-1];
            zero_q <= (fin_i.prod == '0);
        end
    end

    assign valid_o    = valid_q;
    assign cc_valid_o = cc_valid_q;
    assign product_o  = prod_q;
    assign neg_o      = neg_q;
    assign zero_o     = zero_q;
endmodule

// File: rtl/mulhi_unit.sv
// Module: top of the 32x32 multiplier with high-word register.
// Connects the iterative core, the high-word register and the result stage.
module mulhi_unit
    import mulhi_pkg::*;
#(
    parameter int STEP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic              setcc_i,
    input  logic [63:0]       a_i,
    input  logic [63:0]       b_i,
    input  logic              hi_wr_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [63:0]       product_o,
    output logic              cc_valid_o,
    output logic              neg_o,
    output logic              zero_o,
    output logic [63:0]       hi_rdata_o
);
    mul_fin_t fin;

    mulhi_core #(.STEP_BITS(STEP_BITS)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .signed_i (signed_i),
        .setcc_i  (setcc_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .busy_o   (busy_o),
        .fin_o    (fin)
    );

    mulhi_hireg hireg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin_i   (fin),
        .wr_i    (hi_wr_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .rdata_o (hi_rdata_o)
    );

    mulhi_result res_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_i      (fin),
        .valid_o    (valid_o),
        .cc_valid_o (cc_valid_o),
        .product_o  (product_o),
        .neg_o      (neg_o),
        .zero_o     (zero_o)
    );
endmodule

// File: rtl/mulhi_unit_chk.sv
// Checker: port-level properties of mulhi_unit, attached by bind.
module mulhi_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        hi_wr_i,
    input logic        busy_o,
    input logic        valid_o,
    input logic [63:0] product_o,
    input logic        cc_valid_o,
    input logic        neg_o,
    input logic        zero_o,
    input logic [63:0] hi_rdata_o
);
    AST_HI_MATCHES_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> hi_rdata_o[31:0] == product_o[63:32]); // R3
    AST_HI_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rdata_o[63:32] == 32'd0); // R4
    AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !$past(hi_wr_i)) |-> $stable(hi_rdata_o)); // R5
    AST_NO_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !valid_o); // R7
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R8
    AST_CC_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid_o |-> (valid_o && zero_o == (product_o == 64'd0) && neg_o == product_o[63])); // R9
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_valid_o |-> ($stable(neg_o) && $stable(zero_o))); // R10
endmodule

bind mulhi_unit mulhi_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .hi_wr_i    (hi_wr_i),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .product_o  (product_o),
    .cc_valid_o (cc_valid_o),
    .neg_o      (neg_o),
    .zero_o     (zero_o),
    .hi_rdata_o (hi_rdata_o)
);

// File: tb/mulhi_unit_tb_top.sv
// Scoreboard bench for mulhi_unit with default STEP_BITS.
module mulhi_unit_tb_top;
    localparam int STEP_BITS = 4;
    localparam int LAT = 32 / STEP_BITS;

    typedef struct {
        logic [63:0] prod;
        logic        cc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic        setcc_i = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        hi_wr_i = 1'b0;
    logic        busy_o, valid_o, cc_valid_o, neg_o, zero_o;
    logic [63:0] product_o, hi_rdata_o;

    int checks = 0;
    int errors = 0;
    bit ended = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    mulhi_unit #(.STEP_BITS(STEP_BITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .setcc_i(setcc_i), .a_i(a_i), .b_i(b_i), .hi_wr_i(hi_wr_i),
        .busy_o(busy_o), .valid_o(valid_o), .product_o(product_o),
        .cc_valid_o(cc_valid_o), .neg_o(neg_o), .zero_o(zero_o),
        .hi_rdata_o(hi_rdata_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic sg);
        logic [63:0] ea, eb;
        ea = {{32{sg & a[31]}}, a[31:0]};
        eb = {{32{sg & b[31]}}, b[31:0]};
        return ea * eb;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: issue one multiply, push its expectation, wait for idle.
    task automatic run_mul(logic [63:0] a, logic [63:0] b, logic sg, logic cc);
        exp_t e;
        @(negedge clk);
        a_i = a; b_i = b; signed_i = sg; setcc_i = cc; start_i = 1'b1;
        e.prod = model(a, b, sg);
        e.cc = cc;
        sb_q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    // Monitor: compare each completion against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb_q.size() == 0) begin
                check("R8 unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R1/R2 product", product_o, e.prod);
                check("R3 high word", hi_rdata_o, {32'd0, e.prod[63:32]});
                check(e.cc ? "R9 cc pulse" : "R10 cc pulse", {63'd0, cc_valid_o}, {63'd0, e.cc});
                if (e.cc) begin
                    check("R9 negative", {63'd0, neg_o}, {63'd0, e.prod[63]});
                    check("R9 zero", {63'd0, zero_o}, {63'd0, e.prod == 64'd0});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", {63'd0, busy_o}, 64'd0);
        check("R11 valid", {63'd0, valid_o}, 64'd0);
        check("R11 product", product_o, 64'd0);
        check("R11 high word", hi_rdata_o, 64'd0);
        check("R11 flags", {62'd0, neg_o, zero_o}, 64'd0);
        rst_n = 1'b1;

        // R1: unsigned products
        run_mul(64'hFFFF_FFFF_0000_0003, 64'h1234_0000_0000_0005, 1'b0, 1'b0);
        run_mul(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1);
        // R2: signed products incl. correction and extremes
        run_mul(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0007, 1'b1, 1'b1);
        run_mul(64'h0000_0000_0000_0007, 64'hAAAA_AAAA_8000_0000, 1'b1, 1'b0);
        run_mul(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 1'b1);
        run_mul(64'h0000_0000_8765_4321, 64'h0000_0000_FEDC_BA98, 1'b1, 1'b1);

        // R7: valid one cycle, product held
        held = product_o;
        @(negedge clk);
        check("R7 valid pulse width", {63'd0, valid_o}, 64'd0);
        repeat (3) @(negedge clk);
        check("R7 product held", product_o, held);

        // R9/R10: zero result sets flag, then non-cc multiply leaves flags alone
        run_mul(64'd0, 64'h0000_0000_1234_5678, 1'b0, 1'b1);
        run_mul(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0009, 1'b1, 1'b0);
        check("R10 zero held", {63'd0, zero_o}, 64'd1);
        check("R10 negative held", {63'd0, neg_o}, 64'd0);

        // R5 and R4: write high word, read zero-extended
        @(negedge clk);
        a_i = 64'hFFFF_0000_F0F0_1234; b_i = 64'h0F0F_0000_0F0F_0000; hi_wr_i = 1'b1;
        @(negedge clk);
        hi_wr_i = 1'b0;
        check("R5 write value", hi_rdata_o[31:0], {32'd0, 32'hFFFF_1234});
        check("R4 zero extension", {32'd0, hi_rdata_o[63:32]}, 64'd0);

        // R8: extra start while busy is ignored
        @(negedge clk);
        a_i = 64'd3; b_i = 64'd11; signed_i = 1'b0; setcc_i = 1'b0; start_i = 1'b1;
        sb_q.push_back('{prod: 64'd33, cc: 1'b0});
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        a_i = 64'd100; b_i = 64'd100; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (LAT + 3) @(negedge clk);
        check("R8 no extra result", product_o, 64'd33);
        check("R8 queue drained", sb_q.size(), 64'd0);

        // R6: write on the completion cycle loses to the multiply
        @(negedge clk);
        a_i = 64'h0000_0000_FFFF_FFFF; b_i = 64'h0000_0000_FFFF_FFFF;
        signed_i = 1'b0; setcc_i = 1'b0; start_i = 1'b1;
        sb_q.push_back('{prod: model(a_i, b_i, 1'b0), cc: 1'b0});
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        hi_wr_i = 1'b1;
        @(negedge clk);
        hi_wr_i = 1'b0;
        check("R6 multiply wins", hi_rdata_o, 64'h0000_0000_FFFF_FFFE);
        @(negedge clk);
        check("R6 write dropped", hi_rdata_o, 64'h0000_0000_FFFF_FFFE);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule